// File: doc/BRIEF.md
# Burst Access Latency and WAIT Generator

This block is the device-side timing logic of a synchronous burst pseudo-SRAM. It does not contain the memory array. A host programs a small configuration register that sets three things: the initial access latency, the level that counts as an asserted WAIT, and whether WAIT releases one cycle ahead of the first data word or in the same cycle. A burst opens when the address-valid strobe is sampled high on a clock edge while the chip is enabled. The block then counts the configured number of clocks, drives WAIT to its asserted level while it counts, and raises a data-valid strobe when the first word is due. From that point it steps a burst word index once per clock.

The burst runs until chip enable is sampled low. A fresh address-valid strobe in the middle of a burst restarts the latency count. Whenever the chip is deselected, the WAIT pin is released: its output enable drops and the data bit rests at the inactive level. Only two latency settings are accepted, three clocks and four clocks. The shorter one suits lower clock rates. Any other code written to the latency field is discarded.

Top module: `bpsram_wait_gen`

## Requirements
- R1: After reset the latency is four clocks, WAIT is active high and the early WAIT mode is selected; `dvalid` is 0 and `word_idx` is 0.
- R2: A write with `cfg_we` high at a clock edge loads the register. Bits [2:0] hold the latency code, bit 3 is the polarity (1 = asserted WAIT is high), and bit 4 is the timing mode (1 = early, 0 = aligned).
- R3: With latency code 2, `dvalid` first goes high after the third rising edge, counting the edge that samples the strobe as the first. With code 3, it goes high after the fourth.
- R4: A latency code other than 2 or 3 leaves the stored latency unchanged. The polarity and mode bits of the same write are still taken.
- R5: A burst starts when `adv` and `chip_en` are both high at a rising edge. This also applies in the middle of a burst, which then restarts its latency. `adv` with `chip_en` low starts nothing.
- R6: WAIT is asserted in every latency cycle in aligned mode and is deasserted in every cycle where `dvalid` is high.
- R7: In early mode, WAIT is deasserted in the last latency cycle, one cycle before `dvalid` rises.
- R8: Asserted WAIT drives `wait_o` to the polarity bit's value, and deasserted WAIT drives it to the opposite value.
- R9: `wait_oe` equals `chip_en`. While it is 0, `wait_o` rests at the deasserted level.
- R10: `word_idx` is 0 on the first data cycle and increments by one on every later clock of the burst, wrapping modulo 2^IDX_W. `dvalid` stays high throughout.
- R11: A rising edge that samples `chip_en` low ends the burst: `dvalid` and `word_idx` are 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip select, active high |
| adv | input | 1 | Address-valid strobe, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 5 | Configuration write value |
| wait_o | output | 1 | WAIT level |
| wait_oe | output | 1 | WAIT output enable |
| dvalid | output | 1 | Data word valid in this cycle |
| word_idx | output | IDX_W (4) | Index of the current burst word |

## Verification
The bench covers every combination of latency code, polarity and timing mode, and compares the design against a per-cycle expected timeline. A counter that is off by one shows up as a first `dvalid` one clock early or late. A WAIT that misses its early release shows up as an asserted level in the last latency cycle. A design that adopts an illegal latency code changes the burst length, because the bench writes codes 5, 0 and 7 and then checks the old timing. Other stimuli cover a restart strobe inside a burst, a strobe while deselected, and a burst long enough to wrap the index. These catch a design that ignores the restart, wakes without chip enable, or saturates the index instead of wrapping it.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int LAT_W     = 3;
  localparam int CFG_W     = 5;
  localparam int POS_LAT   = 0;
  localparam int POS_POL   = 3;
  localparam int POS_EARLY = 4;

  localparam logic [LAT_W-1:0] LAT_CODE_SHORT = 3'd2;
  localparam logic [LAT_W-1:0] LAT_CODE_LONG  = 3'd3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LAT  = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  typedef struct packed {
    logic             early;
    logic             pol_high;
    logic [LAT_W-1:0] lat_code;
  } cfg_t;

  function automatic logic code_legal(input logic [LAT_W-1:0] code);
    return (code == LAT_CODE_SHORT) || (code == LAT_CODE_LONG);
  endfunction

  // Clocks to first word are code+1, so the countdown preload is the code itself.
  function automatic logic [LAT_W-1:0] lat_preload(input logic [LAT_W-1:0] code);
    return code;
  endfunction
endpackage

// File: rtl/bwg_cfg_reg.sv
module bwg_cfg_reg
  import bwg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);
  cfg_t cfg_q, cfg_d;
  logic [LAT_W-1:0] code_in;

  assign code_in = wdata[POS_LAT +: LAT_W];

  always_comb begin
    cfg_d          = cfg_q;
    cfg_d.pol_high = wdata[POS_POL];
    cfg_d.early    = wdata[POS_EARLY];
    if (code_legal(code_in)) cfg_d.lat_code = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.early    <= 1'b1;
      cfg_q.pol_high <= 1'b1;
      cfg_q.lat_code <= LAT_CODE_LONG;
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/bwg_burst_seq.sv
module bwg_burst_seq
  import bwg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             adv,
  input  logic [LAT_W-1:0] lat_code,
  output phase_t           phase,
  output logic             last_lat,
  output logic [IDX_W-1:0] word_idx
);
  localparam logic [LAT_W-1:0] CNT_ONE = LAT_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  phase_t           ph_q, ph_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cnt_en, idx_en;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    cnt_en = 1'b0;
    idx_en = 1'b0;
    if (!chip_en) begin
      ph_d   = PH_IDLE;
      cnt_d  = '0;
      idx_d  = '0;
      cnt_en = 1'b1;
      idx_en = 1'b1;
    end else if (adv) begin
      ph_d   = PH_LAT;
      cnt_d  = lat_preload(lat_code);
      idx_d  = '0;
      cnt_en = 1'b1;
      idx_en = 1'b1;
    end else begin
      unique case (ph_q)
        PH_LAT: begin
          cnt_en = 1'b1;
          if (cnt_q == CNT_ONE) begin
            ph_d  = PH_DATA;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        PH_DATA: begin
          idx_en = 1'b1;
          idx_d  = idx_q + IDX_ONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign phase    = ph_q;
  assign last_lat = (ph_q == PH_LAT) && (cnt_q == CNT_ONE);
  assign word_idx = idx_q;
endmodule

// File: rtl/bwg_wait_drv.sv
module bwg_wait_drv
  import bwg_pkg::*;
(
  input  phase_t phase,
  input  logic   last_lat,
  input  logic   chip_en,
  input  logic   pol_high,
  input  logic   early,
  output logic   wait_o,
  output logic   wait_oe
);
  logic active;

  always_comb begin
    active = chip_en && (phase == PH_LAT) && !(early && last_lat);
  end

  assign wait_o  = pol_high ? active : !active;
  assign wait_oe = chip_en;
endmodule

// File: rtl/bpsram_wait_gen.sv
module bpsram_wait_gen
  import bwg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             adv,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             wait_o,
  output logic             wait_oe,
  output logic             dvalid,
  output logic [IDX_W-1:0] word_idx
);
  cfg_t   cfg_s;
  phase_t phase_s;
  logic   last_lat_s;

  bwg_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg_s)
  );

  bwg_burst_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_en  (chip_en),
    .adv      (adv),
    .lat_code (cfg_s.lat_code),
    .phase    (phase_s),
    .last_lat (last_lat_s),
    .word_idx (word_idx)
  );

  bwg_wait_drv u_wait (
    .phase    (phase_s),
    .last_lat (last_lat_s),
    .chip_en  (chip_en),
    .pol_high (cfg_s.pol_high),
    .early    (cfg_s.early),
    .wait_o   (wait_o),
    .wait_oe  (wait_oe)
  );

  assign dvalid = (phase_s == PH_DATA);
endmodule

// File: rtl/bwg_chk.sv
module bwg_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_en,
  input logic             adv,
  input logic             dvalid,
  input logic [IDX_W-1:0] word_idx,
  input logic             wait_o,
  input logic             wait_oe,
  input logic             pol_high
);
  // R11
  deselect_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (!dvalid && word_idx == '0));

  // R5
  strobe_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && adv) |=> !dvalid);

  // R10
  index_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && chip_en && !adv) |=> (dvalid && word_idx == $past(word_idx) + 1'b1));

  // R6
  data_wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> (wait_o == !pol_high));

  // R9
  released_pin_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_oe |-> (wait_o == !pol_high));
endmodule

bind bpsram_wait_gen bwg_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_en  (chip_en),
  .adv      (adv),
  .dvalid   (dvalid),
  .word_idx (word_idx),
  .wait_o   (wait_o),
  .wait_oe  (wait_oe),
  .pol_high (cfg_s.pol_high)
);

// File: tb/bpsram_wait_gen_bench.sv
module bpsram_wait_gen_bench;
  localparam int IDX_W = 4;

  typedef struct {
    bit             dv;
    bit             wl;
    bit             oe;
    bit             chk_idx;
    logic [IDX_W-1:0] idx;
    string          tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             chip_en, adv, cfg_we;
  logic [4:0]       cfg_wdata;
  logic             wait_o, wait_oe, dvalid;
  logic [IDX_W-1:0] word_idx;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  bpsram_wait_gen #(.IDX_W(IDX_W)) u_bpsram_wait_gen (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .adv(adv),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .wait_o(wait_o),
    .wait_oe(wait_oe), .dvalid(dvalid), .word_idx(word_idx)
  );

  // monitor: compares one expected item per cycle at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (dvalid !== e.dv || wait_o !== e.wl || wait_oe !== e.oe ||
          (e.chk_idx && word_idx !== e.idx)) begin
        errors++;
        $display("FAIL %s: got dv=%b wait=%b oe=%b idx=%0d, expected dv=%b wait=%b oe=%b idx=%0d",
                 e.tag, dvalid, wait_o, wait_oe, word_idx, e.dv, e.wl, e.oe, e.idx);
      end
    end
  end

  task automatic push(bit dv, bit wl, bit oe, bit ci, int idx, string tag);
    exp_t e;
    e.dv = dv; e.wl = wl; e.oe = oe; e.chk_idx = ci;
    e.idx = IDX_W'(idx); e.tag = tag;
    q.push_back(e);
  endtask

  // one idle cycle with chip disabled; pol gives the rest level
  task automatic idle_cycle(bit pol, string tag);
    @(posedge clk); #1 push(0, !pol, 0, 1, 0, tag);
    @(negedge clk); #2;
  endtask

  task automatic write_cfg(bit early, bit pol_now, bit pol_new, logic [2:0] code, string tag);
    cfg_we = 1'b1; cfg_wdata = {early, pol_new, code};
    @(posedge clk); #1 push(0, !pol_new, 0, 1, 0, tag);
    @(negedge clk); #2 cfg_we = 1'b0;
    if (pol_now != pol_new) ; // level after the edge already uses the new polarity
  endtask

  // drive a burst; expected timeline derived from R3, R6, R7, R8, R10, R11
  task automatic run_burst(int nlat, bit pol, bit early, int nwords, bit drop, string tag);
    chip_en = 1'b1; adv = 1'b1;
    for (int i = 1; i < nlat + nwords; i++) begin
      bit asrt;
      asrt = (i < nlat) && !(early && i == nlat - 1);
      @(posedge clk); #1 push(i >= nlat, asrt ? pol : !pol, 1, i >= nlat, i - nlat, tag);
      @(negedge clk); #2 adv = 1'b0;
    end
    if (drop) begin
      chip_en = 1'b0;
      @(posedge clk); #1 push(0, !pol, 0, 1, 0, "R9 R11");
      @(negedge clk); #2;
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      finish_sim();
    end
  end

  initial begin
    rst_n = 1'b0; chip_en = 1'b0; adv = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    checks++;
    if (dvalid !== 1'b0 || word_idx !== '0 || wait_oe !== 1'b0 || wait_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got dv=%b idx=%0d oe=%b wait=%b, expected 0 0 0 0",
               dvalid, word_idx, wait_oe, wait_o);
    end
    #2 rst_n = 1'b1;
    idle_cycle(1, "R1");
    // R1 default: four clocks, active high, early release
    run_burst(4, 1, 1, 3, 1, "R1 R3 R7");

    // R2 R3 R6 R7 R8 sweep
    for (int c = 2; c <= 3; c++)
      for (int p = 0; p <= 1; p++)
        for (int m = 0; m <= 1; m++) begin
          write_cfg(m[0], 1'b1, p[0], 3'(c), "R2");
          run_burst(c + 1, p[0], m[0], 5, 1, m[0] ? "R2 R3 R7 R8" : "R2 R3 R6 R8");
        end

    // R4 illegal codes keep latency, other fields still taken
    write_cfg(1'b0, 1'b1, 1'b1, 3'd2, "R2");
    write_cfg(1'b0, 1'b1, 1'b1, 3'd5, "R4");
    run_burst(3, 1, 0, 2, 1, "R4");
    write_cfg(1'b1, 1'b1, 1'b0, 3'd7, "R4");
    run_burst(3, 0, 1, 2, 1, "R4 R8");
    write_cfg(1'b0, 1'b0, 1'b1, 3'd3, "R2");
    write_cfg(1'b0, 1'b1, 1'b1, 3'd0, "R4");
    run_burst(4, 1, 0, 2, 1, "R4");

    // R5 strobe while deselected starts nothing
    adv = 1'b1;
    idle_cycle(1, "R5");
    adv = 1'b0;
    idle_cycle(1, "R5");

    // R5 restart mid-burst, then R10 wrap over 18 words
    run_burst(4, 1, 0, 3, 0, "R5");
    run_burst(4, 1, 0, 18, 1, "R5 R10");

    repeat (3) @(negedge clk);
    done = 1;
    finish_sim();
  end
endmodule